// File: doc/BRIEF.md
# Secure illegal-access flag bank

This block gathers violation pulses from fourteen protected resources of a chip and holds each one in a sticky interrupt status flag. A single interrupt line goes high while any flag whose enable bit is set is high. Software running in the secure, privileged world reads the flags and acknowledges them by writing ones to a clear register. It also programs a per-flag interrupt mask.

The register port carries two attribute bits with every transaction, one for secure and one for privileged. Only a transaction with both attributes set reaches the registers. Any other transaction changes nothing and reads back zero. While security is on, such a transaction is itself treated as a violation and is recorded in the flag that belongs to this block's own port. A global security-enable input locks the whole register set while security is off.

Read data is registered. It appears on `reg_rdata` one clock after the request and is zero in every other cycle.

Top module: `sec_viol_flags`

## Requirements
- R1: After a synchronous active-low reset, every status flag and every enable bit is 0, `irq` is 0 and `reg_rdata` is 0.
- R2: A one-cycle high pulse on `viol_evt[i]` sets flag i at the next clock edge. The flag then stays set until it is cleared.
- R3: A legal write to the clear register at offset 0x020 clears every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. Nothing else ever clears a flag.
- R4: When an event pulse and a legal clear of the same flag fall in the same cycle, the flag ends up set.
- R5: A transaction is legal only when `reg_sec` and `reg_priv` are both 1 and `sec_en` is 1. Any other transaction leaves the enable register and the flags untouched and returns 0 read data.
- R6: With `sec_en` at 1, a transaction that lacks the secure or the privileged attribute sets flag 0 at the next clock edge.
- R7: With `sec_en` at 0, every transaction is blocked, returns 0 read data and raises no event, including on flag 0. Event pulses on `viol_evt` still set their flags.
- R8: A legal read returns its data one cycle after the request. Reading offset 0x010 returns the current flags in bits 13..0. Writes to 0x010 have no effect. Reads of the clear register at 0x020, and of any unmapped offset, return 0.
- R9: The enable register at offset 0x000 is read/write in bits 13..0. `irq` is 1 exactly when some flag and its enable bit are both 1.
- R10: Bits 31..14 of every register read as 0, and writing them has no effect.
- R11: Flag bit positions: 0 is this block's own register port, 1 is the firewall configuration unit, 2 is the cipher engine, 3 is the random number generator, 4 is the radio SPI link, 5 is power control, 6 is the flash interface, 7 and 8 are the two DMA controllers, 9 is the DMA request router, 10 is the flash array, 11 and 12 are the two SRAMs, and 13 is the public-key engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_en | input | 1 | Global security enable; 0 locks the registers |
| viol_evt | input | 14 | One-cycle violation pulses, one per protected resource |
| reg_req | input | 1 | Register transaction valid for this cycle |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_sec | input | 1 | Transaction carries the secure attribute |
| reg_priv | input | 1 | Transaction carries the privileged attribute |
| reg_rdata | output | 32 | Registered read data, valid one cycle after the request |
| irq | output | 1 | OR of all enabled flags |

## Verification
The assertions assume that each register transaction lasts exactly one cycle and that attribute bits and address are valid whenever `reg_req` is high. They also assume that `sec_en` only changes between transactions. The directed tasks drive every request for a single cycle, starting at a falling edge, and change `sec_en` only while `reg_req` is low. They also place event pulses either alone or deliberately in the same cycle as a clear, so that the set-wins rule is exercised on purpose.

// File: rtl/sec_viol_flags_pkg.sv
// Package: shared constants and types for the secure violation flag bank.
// Assumes: 14 monitored sources; bit positions are fixed by software.
package sec_viol_flags_pkg;

    localparam int unsigned SRC_OWN_PORT   = 0;
    localparam int unsigned SRC_FW_CONFIG  = 1;
    localparam int unsigned SRC_CIPHER     = 2;
    localparam int unsigned SRC_RNG        = 3;
    localparam int unsigned SRC_RADIO_SPI  = 4;
    localparam int unsigned SRC_POWER      = 5;
    localparam int unsigned SRC_FLASH_IF   = 6;
    localparam int unsigned SRC_DMA_A      = 7;
    localparam int unsigned SRC_DMA_B      = 8;
    localparam int unsigned SRC_DMA_ROUTER = 9;
    localparam int unsigned SRC_FLASH      = 10;
    localparam int unsigned SRC_RAM_A      = 11;
    localparam int unsigned SRC_RAM_B      = 12;
    localparam int unsigned SRC_PUBKEY     = 13;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CLR  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     legal_rd;
        logic     legal_wr;
        logic     reject;
    } acc_t;

endpackage

// File: rtl/svf_access_filter.sv
// Module: svf_access_filter
// Decodes the register offset and filters each transaction on the secure and
// privileged attributes and on the global security enable.
// Assumes: a transaction lasts exactly one cycle while req is high.
module svf_access_filter
    import sec_viol_flags_pkg::*;
#(
    parameter int unsigned AW       = 12,
    parameter logic [AW-1:0] MASK_OFF = 12'h000,
    parameter logic [AW-1:0] STAT_OFF = 12'h010,
    parameter logic [AW-1:0] CLR_OFF  = 12'h020
) (
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic          sec,
    input  logic          priv,
    input  logic          sec_en,
    output acc_t          acc
);

    logic allowed;

    // Offset decode and attribute filter.
    always_comb begin
        allowed = req && sec_en && sec && priv;
        if (addr == MASK_OFF)      acc.sel = SEL_MASK;
        else if (addr == STAT_OFF) acc.sel = SEL_STAT;
        else if (addr == CLR_OFF)  acc.sel = SEL_CLR;
        else                       acc.sel = SEL_NONE;
        acc.legal_wr = allowed && we;
        acc.legal_rd = allowed && !we;
        acc.reject   = req && sec_en && !(sec && priv);
    end

endmodule

// File: rtl/svf_flag_bank.sv
// Module: svf_flag_bank
// One sticky flag per source. A set pulse wins over a same-cycle clear.
// The flag at OWN_BIT also takes the rejected-access event of the register port.
// Assumes: set pulses are already synchronous to clk.
module svf_flag_bank #(
    parameter int unsigned NSRC    = 14,
    parameter int unsigned OWN_BIT = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            own_viol,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] flags
);

    for (genvar i = 0; i < NSRC; i++) begin : g_cell
        logic set_i;
        if (i == OWN_BIT) begin : g_own
            assign set_i = evt[i] | own_viol;
        end else begin : g_ext
            assign set_i = evt[i];
        end

        // Sticky flag: set has priority over write-one clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                      flags[i] <= 1'b0;
            else if (set_i)                  flags[i] <= 1'b1;
            else if (clr_we && clr_mask[i])  flags[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/svf_irq_mask.sv
// Module: svf_irq_mask
// Interrupt enable register and the interrupt OR tree.
// Assumes: bits above NSRC are reserved and are forced to zero on write.
module svf_irq_mask #(
    parameter int unsigned NSRC = 14,
    parameter int unsigned DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [DW-1:0]   wdata,
    input  logic [NSRC-1:0] flags,
    output logic [DW-1:0]   en,
    output logic            irq
);

    localparam logic [DW-1:0] IMPL_MASK = DW'((64'd1 << NSRC) - 64'd1);

    // Enable register update, reserved bits dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)  en <= '0;
        else if (we) en <= wdata & IMPL_MASK;
    end

    // Interrupt is high while any enabled flag is high.
    always_comb irq = |(flags & en[NSRC-1:0]);

endmodule

// File: rtl/svf_rd_port.sv
// Module: svf_rd_port
// Registered read data path: one-cycle latency, zero when no legal read.
// Assumes: acc is the decoded view of the current transaction.
module svf_rd_port
    import sec_viol_flags_pkg::*;
#(
    parameter int unsigned NSRC = 14,
    parameter int unsigned DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  acc_t            acc,
    input  logic [NSRC-1:0] flags,
    input  logic [DW-1:0]   en,
    output logic [DW-1:0]   rdata
);

    logic [DW-1:0] rd_next;

    // Select the addressed register; clear and unmapped offsets read zero.
    always_comb begin
        rd_next = '0;
        if (acc.legal_rd) begin
            case (acc.sel)
                SEL_MASK: rd_next = en;
                SEL_STAT: rd_next = {{(DW-NSRC){1'b0}}, flags};
                default:  rd_next = '0;
            endcase
        end
    end

    // Register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_next;
    end

endmodule

// File: rtl/sec_viol_flags.sv
// Module: sec_viol_flags (top)
// Secure illegal-access flag bank: sticky flags, write-one clear, interrupt
// mask and an attribute-filtered register port whose rejects feed flag 0.
// Assumes: single-cycle register transactions; viol_evt pulses are synchronous.
module sec_viol_flags
    import sec_viol_flags_pkg::*;
#(
    parameter int unsigned NSRC = 14,
    parameter int unsigned DW   = 32,
    parameter int unsigned AW   = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sec_en,
    input  logic [NSRC-1:0] viol_evt,
    input  logic            reg_req,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    input  logic            reg_sec,
    input  logic            reg_priv,
    output logic [DW-1:0]   reg_rdata,
    output logic            irq
);

    acc_t            acc;
    logic [NSRC-1:0] flags;
    logic [DW-1:0]   irq_en;
    logic            clr_we;
    logic            mask_we;

    svf_access_filter #(
        .AW(AW), .MASK_OFF(AW'(12'h000)), .STAT_OFF(AW'(12'h010)), .CLR_OFF(AW'(12'h020))
    ) u_filter (
        .req(reg_req), .we(reg_we), .addr(reg_addr), .sec(reg_sec),
        .priv(reg_priv), .sec_en(sec_en), .acc(acc)
    );

    // Per-register write strobes.
    always_comb begin
        clr_we  = acc.legal_wr && (acc.sel == SEL_CLR);
        mask_we = acc.legal_wr && (acc.sel == SEL_MASK);
    end

    svf_flag_bank #(.NSRC(NSRC), .OWN_BIT(SRC_OWN_PORT)) u_bank (
        .clk(clk), .rst_n(rst_n), .evt(viol_evt), .own_viol(acc.reject),
        .clr_we(clr_we), .clr_mask(reg_wdata[NSRC-1:0]), .flags(flags)
    );

    svf_irq_mask #(.NSRC(NSRC), .DW(DW)) u_mask (
        .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(reg_wdata),
        .flags(flags), .en(irq_en), .irq(irq)
    );

    svf_rd_port #(.NSRC(NSRC), .DW(DW)) u_rd (
        .clk(clk), .rst_n(rst_n), .acc(acc), .flags(flags),
        .en(irq_en), .rdata(reg_rdata)
    );

endmodule

// File: rtl/sec_viol_flags_chk.sv
// Module: sec_viol_flags_chk
// Property checker bound into sec_viol_flags.
// Assumes: single-cycle transactions and sec_en stable during a transaction.
module sec_viol_flags_chk #(
    parameter int unsigned NSRC = 14,
    parameter int unsigned DW   = 32,
    parameter int unsigned AW   = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sec_en,
    input logic [NSRC-1:0] viol_evt,
    input logic            reg_req,
    input logic            reg_we,
    input logic [AW-1:0]   reg_addr,
    input logic            reg_sec,
    input logic            reg_priv,
    input logic [DW-1:0]   reg_rdata,
    input logic            irq,
    input logic [NSRC-1:0] flags,
    input logic [DW-1:0]   irq_en
);

    logic good_clr;
    logic rejected;

    // Helper terms taken from the ports.
    always_comb begin
        good_clr = reg_req && reg_we && sec_en && reg_sec && reg_priv
                   && (reg_addr == AW'(12'h020));
        rejected = reg_req && sec_en && !(reg_sec && reg_priv);
    end

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_evt != '0) |=> ((flags & $past(viol_evt)) == $past(viol_evt)));

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (good_clr && viol_evt != '0) |=> ((flags & $past(viol_evt)) == $past(viol_evt)));

    assert_only_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flags) & ~flags) != '0) |-> $past(good_clr));

    assert_reject_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !(reg_sec && reg_priv)) |=> (reg_rdata == '0));

    assert_reject_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |=> flags[0]);

    assert_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !sec_en) |=> (reg_rdata == '0 && $stable(irq_en)));

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DW-1:NSRC] == '0);

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));

endmodule

bind sec_viol_flags sec_viol_flags_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sec_en(sec_en), .viol_evt(viol_evt),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_sec(reg_sec),
    .reg_priv(reg_priv), .reg_rdata(reg_rdata), .irq(irq), .flags(flags),
    .irq_en(irq_en)
);

// File: tb/sec_viol_flags_bench.sv
// Directed bench for sec_viol_flags: one task per scenario.
module sec_viol_flags_bench;

    localparam logic [11:0] A_MASK = 12'h000;
    localparam logic [11:0] A_STAT = 12'h010;
    localparam logic [11:0] A_CLR  = 12'h020;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_en = 1'b1;
    logic [13:0] viol_evt = '0;
    logic        reg_req = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_sec = 1'b0;
    logic        reg_priv = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sec_viol_flags u_sec_viol_flags (
        .clk(clk), .rst_n(rst_n), .sec_en(sec_en), .viol_evt(viol_evt),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_sec(reg_sec), .reg_priv(reg_priv),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One-cycle transaction with an optional event pulse in the same cycle.
    task automatic acc(input logic we, input logic [11:0] a, input logic [31:0] wd,
                       input logic s, input logic p, input logic [13:0] ev,
                       output logic [31:0] rd);
        @(negedge clk);
        reg_req = 1'b1; reg_we = we; reg_addr = a; reg_wdata = wd;
        reg_sec = s; reg_priv = p; viol_evt = ev;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0; viol_evt = '0;
        rd = reg_rdata;
    endtask

    task automatic pulse(input logic [13:0] ev);
        @(negedge clk); viol_evt = ev;
        @(negedge clk); viol_evt = '0;
    endtask

    task automatic rd_ok(input logic [11:0] a, output logic [31:0] rd);
        acc(1'b0, a, 32'h0, 1'b1, 1'b1, 14'h0, rd);
    endtask

    task automatic wr_ok(input logic [11:0] a, input logic [31:0] wd);
        logic [31:0] d;
        acc(1'b1, a, wd, 1'b1, 1'b1, 14'h0, d);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 rdata after reset", reg_rdata, 32'h0);
        chk("R1 irq after reset", {31'h0, irq}, 32'h0);
        rd_ok(A_STAT, d); chk("R1 flags after reset", d, 32'h0);
        rd_ok(A_MASK, d); chk("R1 enables after reset", d, 32'h0);
    endtask

    task automatic t_set_clear;
        logic [31:0] d;
        pulse(14'h2A5A);
        @(negedge clk);
        rd_ok(A_STAT, d); chk("R2 flags held", d, 32'h2A5A);
        wr_ok(A_CLR, 32'h0);
        rd_ok(A_STAT, d); chk("R3 zero write no effect", d, 32'h2A5A);
        wr_ok(A_CLR, 32'h0A42);
        rd_ok(A_STAT, d); chk("R3 partial clear", d, 32'h2018);
        rd_ok(A_CLR, d); chk("R8 clear reg reads zero", d, 32'h0);
        wr_ok(A_STAT, 32'h0000_3FFF);
        rd_ok(A_STAT, d); chk("R8 status write ignored", d, 32'h2018);
        wr_ok(A_CLR, 32'hFFFF_FFFF);
        rd_ok(A_STAT, d); chk("R3 full clear", d, 32'h0);
    endtask

    task automatic t_set_wins;
        logic [31:0] d;
        pulse(14'h0080);
        acc(1'b1, A_CLR, 32'h0000_0081, 1'b1, 1'b1, 14'h0081, d);
        rd_ok(A_STAT, d); chk("R4 set beats clear", d, 32'h0081);
        wr_ok(A_CLR, 32'h0000_3FFF);
        rd_ok(A_STAT, d); chk("R4 later clear works", d, 32'h0);
    endtask

    task automatic t_illegal;
        logic [31:0] d;
        acc(1'b1, A_MASK, 32'h3FFF, 1'b0, 1'b1, 14'h0, d);
        rd_ok(A_MASK, d); chk("R5 nonsecure write ignored", d, 32'h0);
        rd_ok(A_STAT, d); chk("R6 own-port flag set", d, 32'h0001);
        pulse(14'h1000);
        acc(1'b0, A_STAT, 32'h0, 1'b1, 1'b0, 14'h0, d);
        chk("R5 unprivileged read zero", d, 32'h0);
        acc(1'b1, A_CLR, 32'h3FFF, 1'b1, 1'b0, 14'h0, d);
        rd_ok(A_STAT, d); chk("R5 unprivileged clear ignored", d, 32'h1001);
        wr_ok(A_CLR, 32'h3FFF);
        rd_ok(12'h044, d); chk("R8 unmapped reads zero", d, 32'h0);
        rd_ok(A_STAT, d); chk("R6 legal unmapped no event", d, 32'h0);
    endtask

    task automatic t_secoff;
        logic [31:0] d;
        pulse(14'h0008);
        @(negedge clk); sec_en = 1'b0;
        acc(1'b1, A_CLR, 32'h3FFF, 1'b1, 1'b1, 14'h0, d);
        acc(1'b1, A_MASK, 32'h3FFF, 1'b1, 1'b1, 14'h0, d);
        acc(1'b0, A_STAT, 32'h0, 1'b1, 1'b1, 14'h0, d);
        chk("R7 locked read zero", d, 32'h0);
        acc(1'b0, A_STAT, 32'h0, 1'b0, 1'b0, 14'h0, d);
        pulse(14'h0020);
        @(negedge clk); sec_en = 1'b1;
        rd_ok(A_STAT, d); chk("R7 locked clear blocked, no own event", d, 32'h0028);
        rd_ok(A_MASK, d); chk("R7 locked enable write blocked", d, 32'h0);
        wr_ok(A_CLR, 32'h3FFF);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        pulse(14'h0210);
        wr_ok(A_MASK, 32'h0000_0004);
        chk("R9 irq off, no enabled flag", {31'h0, irq}, 32'h0);
        wr_ok(A_MASK, 32'h0000_0010);
        chk("R9 irq on, enabled flag", {31'h0, irq}, 32'h1);
        wr_ok(A_CLR, 32'h0000_0010);
        chk("R9 irq drops after clear", {31'h0, irq}, 32'h0);
        wr_ok(A_MASK, 32'hFFFF_FFFF);
        rd_ok(A_MASK, d); chk("R10 reserved enable bits zero", d, 32'h0000_3FFF);
        chk("R9 irq on via bit 9", {31'h0, irq}, 32'h1);
        wr_ok(A_CLR, 32'hFFFF_C000);
        rd_ok(A_STAT, d); chk("R10 reserved clear bits no effect", d, 32'h0200);
        wr_ok(A_CLR, 32'h3FFF);
        wr_ok(A_MASK, 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] d;
        for (int i = 0; i < 14; i++) begin
            pulse(14'(1 << i));
            rd_ok(A_STAT, d);
            chk($sformatf("R11 source bit %0d", i), d, 32'(1 << i));
            wr_ok(A_CLR, 32'(1 << i));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_set_wins();
        t_illegal();
        t_secoff();
        t_irq();
        t_map();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule